// File: doc/BRIEF.md
# Interleaved Weighted Distance Accumulator

This block computes, for a block of input vectors, the variance-weighted squared distance of each vector from a shared mean vector: for vector `v` the result is the sum over all elements `e` of `(x[v][e] - mean[e])^2 * invvar[e]`. All arithmetic is exact fixed point. One pipelined adder with a latency of several cycles serves every vector in the block. The element index is the outer loop and the vector index is the inner loop, so each vector keeps its own partial-sum register. By the time a vector's next term reaches the adder, the update of that vector's previous sum has already left the pipeline. A new term enters every cycle.

A single pulse on `start` begins a block. The block fetches its samples through a read port that addresses them by vector and element. It fetches the mean and inverse-variance pairs through a second port, one word per element. That word is read once and reused for every vector in the block. When a vector's last element has been added, its sum is presented for one cycle together with the vector index, and its partial-sum register returns to zero for the next block.

Top module: `ilv_dist_accum`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `res_valid`, `x_rd_en` and `mv_rd_en` are 0.
- R2: A `start` pulse seen while `busy` is 0 raises `busy` in the next cycle. From that cycle on, `x_rd_en` is high for NUM_VEC*NUM_ELEM consecutive cycles (390 by default). Read `k` of the block (k counting from 0) addresses vector `k mod NUM_VEC` and element `k div NUM_VEC`. `x_rd_en` is 0 at every other time.
- R3: `mv_rd_en` is high only in the cycles that read vector 0, with `mv_addr` equal to the element index. That is one read per element, NUM_VEC cycles apart.
- R4: Both read ports have a latency of one cycle. The block uses `x_data` and `mv_data` in the cycle after the matching read enable.
- R5: In a mean/variance word, bits [DATA_W-1:0] hold the mean as a two's-complement value and bits [DATA_W+INV_W-1:DATA_W] hold the inverse variance as an unsigned value. All higher bits are ignored. Samples are two's complement.
- R6: `res_sum` equals the exact sum over all elements of `(x - mean)^2 * invvar`, with no rounding or truncation, for every vector.
- R7: Results appear in vector order 0 to NUM_VEC-1, in consecutive cycles, each with `res_valid` high for one cycle. The result for vector `v` is presented 384 + v + ADD_LAT cycles after the cycle in which `start` was high (for the default sizes).
- R8: Partial sums are zero at the start of every block. A block started in the same cycle the previous block's last result appears still yields exact sums.
- R9: `start` has no effect while `busy` is 1. It causes no extra reads and no extra results, and the running block's results are unchanged.
- R10: `busy` is 0 in the cycle that presents the result of vector NUM_VEC-1, and from then on until the next accepted `start`.
- R11: ADD_LAT lies between 1 and NUM_VEC. A vector's partial sum is never read for a new term while its own previous update is still inside the adder pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a block |
| busy | output | 1 | High while a block is being processed |
| x_rd_en | output | 1 | Sample read enable |
| x_vec | output | 4 | Sample read vector index |
| x_elem | output | 6 | Sample read element index |
| x_data | input | 12 | Sample returned one cycle after the read |
| mv_rd_en | output | 1 | Mean/variance read enable |
| mv_addr | output | 6 | Mean/variance element address |
| mv_data | input | 64 | Mean/variance word returned one cycle after the read |
| res_valid | output | 1 | Result strobe |
| res_vec | output | 4 | Vector index of the result |
| res_sum | output | 44 | Completed weighted distance sum |

## Verification
At the default adder latency of four cycles, the result for vector `v` is due exactly 388 + v cycles after the cycle in which `start` was high, and `busy` drops in the cycle of the last result. The driver records each accepted start cycle and queues, for every vector, its exact sum together with that due cycle. The monitor samples on the falling edge, pops one entry for each strobe and compares the index, the sum and the cycle number. It flags any strobe that comes early, late or without an expected entry. The same monitor checks every cycle against the read schedule derived from the start cycle, so the one-cycle read latency and the word reuse are held to exact cycles.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned DEF_NUM_VEC  = 10;
    localparam int unsigned DEF_NUM_ELEM = 39;
    localparam int unsigned DEF_DATA_W   = 12;
    localparam int unsigned DEF_INV_W    = 12;
    localparam int unsigned DEF_MV_W     = 64;
    localparam int unsigned DEF_ADD_LAT  = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_e;

    // flags travelling with a term through the datapath
    typedef struct packed {
        logic valid;
        logic last;   // final element of this vector
        logic fresh;  // a new mean/variance word arrives with this slot
    } slot_flags_t;

    // width of (x - mean)^2 * invvar
    function automatic int unsigned term_width(int unsigned dw, int unsigned iw);
        return 2 * (dw + 1) + iw;
    endfunction

    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ilv_seq.sv
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int unsigned NUM_VEC  = DEF_NUM_VEC,
    parameter int unsigned NUM_ELEM = DEF_NUM_ELEM,
    localparam int unsigned VW = idx_width(NUM_VEC),
    localparam int unsigned EW = idx_width(NUM_ELEM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          drain_done,
    output logic          busy,
    output logic          x_rd_en,
    output logic [VW-1:0] x_vec,
    output logic [EW-1:0] x_elem,
    output logic          mv_rd_en,
    output logic [EW-1:0] mv_addr,
    output slot_flags_t   tag_flags,
    output logic [VW-1:0] tag_vec
);

    seq_state_e    state_q;
    logic [VW-1:0] vec_q;
    logic [EW-1:0] elem_q;
    logic          issuing;
    logic          vec_wrap;
    logic          last_issue;

    assign issuing    = (state_q == SEQ_RUN);
    assign vec_wrap   = (vec_q == VW'(NUM_VEC - 1));
    assign last_issue = issuing && vec_wrap && (elem_q == EW'(NUM_ELEM - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            vec_q   <= '0;
            elem_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    vec_q  <= '0;
                    elem_q <= '0;
                    if (start) state_q <= SEQ_RUN;
                end
                SEQ_RUN: begin
                    if (vec_wrap) begin
                        vec_q  <= '0;
                        elem_q <= elem_q + EW'(1);
                    end else begin
                        vec_q <= vec_q + VW'(1);
                    end
                    if (last_issue) state_q <= SEQ_DRAIN;
                end
                SEQ_DRAIN: if (drain_done) state_q <= SEQ_IDLE;
                default:   state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != SEQ_IDLE);
    assign x_rd_en  = issuing;
    assign x_vec    = vec_q;
    assign x_elem   = elem_q;
    assign mv_rd_en = issuing && (vec_q == '0);
    assign mv_addr  = elem_q;

    // tag lines up with the read data one cycle later
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_flags <= '0;
            tag_vec   <= '0;
        end else begin
            tag_flags.valid <= issuing;
            tag_flags.last  <= (elem_q == EW'(NUM_ELEM - 1));
            tag_flags.fresh <= (vec_q == '0);
            tag_vec         <= vec_q;
        end
    end

    // checker state: cycles since the last mean/variance read in this block
    logic [VW-1:0] mv_gap_q;
    logic          mv_seen_q;
    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            mv_gap_q  <= '0;
            mv_seen_q <= 1'b0;
        end else if (mv_rd_en) begin
            mv_gap_q  <= '0;
            mv_seen_q <= 1'b1;
        end else if (x_rd_en) begin
            mv_gap_q  <= mv_gap_q + VW'(1);
        end
    end

    p_read_order_r2: assert property (@(posedge clk) disable iff (rst)
        (x_rd_en && $past(x_rd_en)) |->
            ((x_vec == '0) ? ($past(x_vec) == VW'(NUM_VEC - 1) && x_elem == $past(x_elem) + EW'(1))
                           : (x_vec == $past(x_vec) + VW'(1) && x_elem == $past(x_elem))));

    p_mv_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        (mv_rd_en && mv_seen_q) |-> (mv_gap_q == VW'(NUM_VEC - 1)));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !drain_done) |=> (busy && $stable(x_rd_en || !x_rd_en)));

endmodule

// File: rtl/ilv_term.sv
module ilv_term
    import ilv_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned INV_W  = DEF_INV_W,
    parameter int unsigned MV_W   = DEF_MV_W,
    parameter int unsigned VW     = 4,
    localparam int unsigned TW    = term_width(DATA_W, INV_W),
    localparam int unsigned PW    = DATA_W + INV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_flags_t       in_flags,
    input  logic [VW-1:0]     in_vec,
    input  logic [DATA_W-1:0] x_data,
    input  logic [MV_W-1:0]   mv_data,
    output logic              term_valid,
    output logic              term_last,
    output logic [VW-1:0]     term_vec,
    output logic [TW-1:0]     term_val
);

    logic [PW-1:0]          mv_hold_q;
    logic [PW-1:0]          pair_c;
    logic [DATA_W-1:0]      mean_c;
    logic [INV_W-1:0]       inv_c;
    logic signed [DATA_W:0] diff_c;
    logic [MV_W-PW-1:0]     unused_mv_hi;

    assign unused_mv_hi = mv_data[MV_W-1:PW];
    assign pair_c = in_flags.fresh ? mv_data[PW-1:0] : mv_hold_q;
    assign mean_c = pair_c[DATA_W-1:0];
    assign inv_c  = pair_c[PW-1:DATA_W];
    assign diff_c = $signed({x_data[DATA_W-1], x_data}) - $signed({mean_c[DATA_W-1], mean_c});

    always_ff @(posedge clk) begin
        if (rst) mv_hold_q <= '0;
        else if (in_flags.valid && in_flags.fresh) mv_hold_q <= mv_data[PW-1:0];
    end

    // stage A: difference
    logic                   a_valid, a_last;
    logic [VW-1:0]          a_vec;
    logic signed [DATA_W:0] a_diff;
    logic [INV_W-1:0]       a_inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_valid <= 1'b0;
            a_last  <= 1'b0;
            a_vec   <= '0;
            a_diff  <= '0;
            a_inv   <= '0;
        end else begin
            a_valid <= in_flags.valid;
            a_last  <= in_flags.last;
            a_vec   <= in_vec;
            a_diff  <= diff_c;
            a_inv   <= inv_c;
        end
    end

    // stage B: square and weight
    logic signed [2*DATA_W+1:0] sq_c;
    logic [TW-1:0]              prod_c;

    assign sq_c   = a_diff * a_diff;
    assign prod_c = TW'($unsigned(sq_c)) * TW'(a_inv);

    always_ff @(posedge clk) begin
        if (rst) begin
            term_valid <= 1'b0;
            term_last  <= 1'b0;
            term_vec   <= '0;
            term_val   <= '0;
        end else begin
            term_valid <= a_valid;
            term_last  <= a_last;
            term_vec   <= a_vec;
            term_val   <= prod_c;
        end
    end

endmodule

// File: rtl/ilv_accum.sv
module ilv_accum
    import ilv_pkg::*;
#(
    parameter int unsigned NUM_VEC = DEF_NUM_VEC,
    parameter int unsigned ADD_LAT = DEF_ADD_LAT,
    parameter int unsigned TW      = 38,
    parameter int unsigned ACC_W   = 44,
    parameter int unsigned VW      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             term_valid,
    input  logic             term_last,
    input  logic [VW-1:0]    term_vec,
    input  logic [TW-1:0]    term_val,
    output logic             res_valid,
    output logic [VW-1:0]    res_vec,
    output logic [ACC_W-1:0] res_sum,
    output logic             drain_done
);

    typedef struct packed {
        logic             valid;
        logic             last;
        logic [VW-1:0]    vec;
        logic [ACC_W-1:0] sum;
    } add_stage_t;

    logic [ACC_W-1:0] acc_q [NUM_VEC];
    add_stage_t       head;
    add_stage_t       wb;

    // the partial sum is read as the term enters the adder
    always_comb begin
        head.valid = term_valid;
        head.last  = term_last;
        head.vec   = term_vec;
        head.sum   = acc_q[term_vec] + ACC_W'(term_val);
    end

    generate
        if (ADD_LAT < 1 || ADD_LAT > NUM_VEC) begin : g_bad_lat
            $error("ADD_LAT must lie between 1 and NUM_VEC");
        end
        if (ADD_LAT == 1) begin : g_direct
            assign wb = head;
        end else begin : g_pipe
            add_stage_t pipe_q [ADD_LAT-1];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < ADD_LAT - 1; k++) pipe_q[k] <= '0;
                end else begin
                    pipe_q[0] <= head;
                    for (int k = 1; k < ADD_LAT - 1; k++) pipe_q[k] <= pipe_q[k-1];
                end
            end
            assign wb = pipe_q[ADD_LAT-2];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_VEC; i++) acc_q[i] <= '0;
            res_valid <= 1'b0;
            res_vec   <= '0;
            res_sum   <= '0;
        end else begin
            res_valid <= 1'b0;
            if (wb.valid) begin
                if (wb.last) begin
                    acc_q[wb.vec] <= '0;
                    res_valid     <= 1'b1;
                    res_vec       <= wb.vec;
                    res_sum       <= wb.sum;
                end else begin
                    acc_q[wb.vec] <= wb.sum;
                end
            end
        end
    end

    assign drain_done = wb.valid && wb.last && (wb.vec == VW'(NUM_VEC - 1));

    p_no_hazard_r11: assert property (@(posedge clk) disable iff (rst)
        (ADD_LAT > 1 && head.valid && wb.valid) |-> (head.vec != wb.vec));

    p_result_order_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(res_valid)) |-> (res_vec == $past(res_vec) + VW'(1)));

    p_first_result_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> (res_vec == '0));

endmodule

// File: rtl/ilv_dist_accum.sv
module ilv_dist_accum
    import ilv_pkg::*;
#(
    parameter int unsigned NUM_VEC  = DEF_NUM_VEC,
    parameter int unsigned NUM_ELEM = DEF_NUM_ELEM,
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned INV_W    = DEF_INV_W,
    parameter int unsigned MV_W     = DEF_MV_W,
    parameter int unsigned ADD_LAT  = DEF_ADD_LAT,
    localparam int unsigned VW      = idx_width(NUM_VEC),
    localparam int unsigned EW      = idx_width(NUM_ELEM),
    localparam int unsigned TW      = term_width(DATA_W, INV_W),
    localparam int unsigned ACC_W   = TW + $clog2(NUM_ELEM + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              x_rd_en,
    output logic [VW-1:0]     x_vec,
    output logic [EW-1:0]     x_elem,
    input  logic [DATA_W-1:0] x_data,
    output logic              mv_rd_en,
    output logic [EW-1:0]     mv_addr,
    input  logic [MV_W-1:0]   mv_data,
    output logic              res_valid,
    output logic [VW-1:0]     res_vec,
    output logic [ACC_W-1:0]  res_sum
);

    slot_flags_t   tag_flags;
    logic [VW-1:0] tag_vec;
    logic          drain_done;
    logic          term_valid, term_last;
    logic [VW-1:0] term_vec;
    logic [TW-1:0] term_val;

    ilv_seq #(.NUM_VEC(NUM_VEC), .NUM_ELEM(NUM_ELEM)) u_seq (
        .clk(clk), .rst(rst), .start(start), .drain_done(drain_done),
        .busy(busy), .x_rd_en(x_rd_en), .x_vec(x_vec), .x_elem(x_elem),
        .mv_rd_en(mv_rd_en), .mv_addr(mv_addr),
        .tag_flags(tag_flags), .tag_vec(tag_vec)
    );

    ilv_term #(.DATA_W(DATA_W), .INV_W(INV_W), .MV_W(MV_W), .VW(VW)) u_term (
        .clk(clk), .rst(rst), .in_flags(tag_flags), .in_vec(tag_vec),
        .x_data(x_data), .mv_data(mv_data),
        .term_valid(term_valid), .term_last(term_last),
        .term_vec(term_vec), .term_val(term_val)
    );

    ilv_accum #(.NUM_VEC(NUM_VEC), .ADD_LAT(ADD_LAT), .TW(TW), .ACC_W(ACC_W), .VW(VW)) u_accum (
        .clk(clk), .rst(rst), .term_valid(term_valid), .term_last(term_last),
        .term_vec(term_vec), .term_val(term_val),
        .res_valid(res_valid), .res_vec(res_vec), .res_sum(res_sum),
        .drain_done(drain_done)
    );

    p_busy_drop_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (res_valid && res_vec == VW'(NUM_VEC - 1)));

    p_reads_only_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (x_rd_en || mv_rd_en) |-> busy);

endmodule

// File: tb/ilv_dist_accum_test.sv
module ilv_dist_accum_test;

    localparam int NV   = 10;
    localparam int NE   = 39;
    localparam int LAT  = 4;
    localparam int ACCW = 44;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            busy, x_rd_en, mv_rd_en, res_valid;
    logic [3:0]      x_vec, res_vec;
    logic [5:0]      x_elem, mv_addr;
    logic [11:0]     x_data = '0;
    logic [63:0]     mv_data = '0;
    logic [ACCW-1:0] res_sum;

    always #2 clk = ~clk;   // 250 MHz

    ilv_dist_accum uut (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .x_rd_en(x_rd_en), .x_vec(x_vec), .x_elem(x_elem), .x_data(x_data),
        .mv_rd_en(mv_rd_en), .mv_addr(mv_addr), .mv_data(mv_data),
        .res_valid(res_valid), .res_vec(res_vec), .res_sum(res_sum)
    );

    logic [11:0] xm  [NV][NE];
    logic [63:0] mvm [NE];

    // one-cycle synchronous read memories (R4)
    always @(posedge clk) begin
        if (x_rd_en)  x_data  <= xm[x_vec][x_elem];
        if (mv_rd_en) mv_data <= mvm[mv_addr];
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    typedef struct { int vec; longint sum; int due; } exp_t;
    exp_t   sb [$];
    exp_t   mon_item;
    longint exp_sum [NV];
    int     blk_s = -100000;
    int     rd_err = 0, mv_err = 0, mv_cnt = 0;

    int unsigned lcg = 32'h1234_5678;
    function automatic int unsigned next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg >> 8;
    endfunction

    task automatic fill(input int kind);
        for (int e = 0; e < NE; e++) begin
            logic [11:0] mn, iv;
            if (kind == 1) begin
                mn = (e % 2 == 0) ? 12'h7FF : 12'h800;
                iv = 12'hFFF;
                mvm[e] = {40'hDEADBEEF00 ^ 40'(e), iv, mn};   // upper bits must be ignored (R5)
            end else begin
                mn = 12'(next_rand());
                iv = 12'(next_rand());
                mvm[e] = {40'h0, iv, mn};
            end
            for (int v = 0; v < NV; v++) begin
                if (kind == 1) xm[v][e] = (v < 5) ? ~mn : mn;
                else if (kind == 2) xm[v][e] = 12'(next_rand() % 64) - 12'd32;
                else xm[v][e] = 12'(next_rand());
            end
        end
        for (int v = 0; v < NV; v++) begin
            exp_sum[v] = 0;
            for (int e = 0; e < NE; e++) begin
                longint d;
                d = longint'($signed(xm[v][e])) - longint'($signed(mvm[e][11:0]));
                exp_sum[v] += d * d * longint'(mvm[e][23:12]);
            end
        end
    endtask

    // called at a negedge with busy low; start high in this cycle
    task automatic fire();
        start = 1'b1;
        blk_s = cyc;
        for (int v = 0; v < NV; v++) begin
            exp_t it;
            it.vec = v; it.sum = exp_sum[v]; it.due = blk_s + 384 + v + LAT;
            sb.push_back(it);
        end
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (busy);
        chk(res_valid == 1'b1 && int'(res_vec) == NV - 1, "R10 busy low at last result",
            longint'(res_vec), NV - 1);
    endtask

    // monitor: results and read schedule
    always @(negedge clk) begin
        if (!rst) begin
            int rel;
            rel = cyc - blk_s - 1;
            if (rel >= 0 && rel < NV * NE) begin
                if (!(x_rd_en && int'(x_vec) == rel % NV && int'(x_elem) == rel / NV)) rd_err++;
                if (mv_rd_en != (rel % NV == 0)) mv_err++;
                if (mv_rd_en && int'(mv_addr) != rel / NV) mv_err++;
            end else begin
                if (x_rd_en) rd_err++;
                if (mv_rd_en) mv_err++;
            end
            if (mv_rd_en) mv_cnt++;

            if (res_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected result", longint'(res_vec), -1);
                end else begin
                    mon_item = sb.pop_front();
                    chk(int'(res_vec) == mon_item.vec && cyc == mon_item.due,
                        "R7 result index/cycle", longint'(cyc), longint'(mon_item.due));
                    chk(longint'(res_sum) == mon_item.sum, "R6 R11 exact sum (R4 R5 R8)",
                        longint'(res_sum), mon_item.sum);
                end
            end else if (sb.size() > 0 && cyc > sb[0].due) begin
                mon_item = sb.pop_front();
                chk(1'b0, "R7 missing result", longint'(cyc), longint'(mon_item.due));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !res_valid && !x_rd_en && !mv_rd_en, "R1 outputs in reset",
            longint'({busy, res_valid, x_rd_en, mv_rd_en}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !res_valid && !x_rd_en && !mv_rd_en, "R1 outputs after reset",
            longint'({busy, res_valid, x_rd_en, mv_rd_en}), 0);

        // block 0: pseudo-random full-range data
        fill(0);
        fire();
        wait_done();

        // block 1: started back to back, extreme values, junk upper bits (R5, R8)
        fill(1);
        fire();
        wait_done();

        // block 2: small data, start pulses while busy (R9)
        repeat (5) @(negedge clk);
        fill(2);
        fire();
        repeat (50) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        chk(!busy && !x_rd_en, "R9 start while busy not kept", longint'({busy, x_rd_en}), 0);

        chk(rd_err == 0, "R2 sample read schedule", rd_err, 0);
        chk(mv_err == 0, "R3 mean/variance read schedule", mv_err, 0);
        chk(mv_cnt == 3 * NE, "R3 mean/variance read count", mv_cnt, 3 * NE);
        chk(sb.size() == 0, "R7 all results seen", sb.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule